// File: doc/BRIEF.md
# Warp Issue Scheduler with Stall Tracking

This block is a single warp scheduler for one processing block of a SIMT core. It holds a fixed pool of warp slots. An admission controller fills the slots, and each slot tags its warp with the ID of the block it belongs to. Each slot is in one of four states: empty, eligible, stalled or retired. In every cycle the scheduler grants issue to at most one eligible warp. The grant rotates fairly across the pool, and the lane mask sends the same instruction to every lane of the chosen warp.

Pipeline logic outside the block reports three kinds of event. The first is a stall, with its cause: a memory access, a barrier wait or an unresolved dependency. The second is a wakeup on one of three cause-specific channels, each tagged with a warp ID. The third is a warp finishing its last instruction. A stalled warp waits until a wakeup of its own cause arrives. A finished warp retires and is never granted again. Each retirement is reported upward one cycle later, carrying the warp ID and the block ID, so that the slot's resources can be reclaimed. Instruction fetch, decode and the execution lanes live elsewhere.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every slot is empty, `issue_valid_o` is 0 and `retire_valid_o` is 0.
- R2: An admit to an empty or retired slot makes that slot eligible and records `admit_block_i`. An admit to an eligible or stalled slot is ignored, and the slot keeps its original block ID.
- R3: At most one warp is granted per cycle, and only a warp that is eligible in that cycle. While granted, `issue_lane_mask_o` is all ones; otherwise it is zero.
- R4: Grants are round-robin. The search starts at the warp after the one granted most recently, wrapping modulo the pool size, and starts at warp 0 after reset.
- R5: A stall request with a nonzero cause code moves an eligible or stalled warp to stalled from the next cycle on. The cause codes are 1 = memory, 2 = barrier and 3 = dependency. Cause code 0 is ignored.
- R6: A stalled warp becomes eligible on the clock edge at which a wakeup of its own cause arrives for its ID. It can be granted in the cycle that follows. A wakeup of any other cause leaves it stalled.
- R7: If a stall request and a wakeup hit the same warp in the same cycle, the stall wins: the warp stays stalled under the new cause.
- R8: When no warp is eligible, `issue_valid_o` is 0 and `issue_warp_o` is 0.
- R9: A done event for an eligible or stalled warp retires it, and it is never granted while retired. In the next cycle only, `retire_valid_o` pulses with the warp ID and the block ID recorded at admission. Done takes priority over a stall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| admit_valid_i | input | 1 | Admit a warp into a slot |
| admit_warp_i | input | WID_W | Slot index to admit |
| admit_block_i | input | BLK_W | Parent block ID of the admitted warp |
| stall_valid_i | input | 1 | Stall request |
| stall_warp_i | input | WID_W | Warp to stall |
| stall_cause_i | input | 2 | Cause code: 1 = memory, 2 = barrier, 3 = dependency |
| mem_wake_valid_i | input | 1 | Memory return wakeup |
| mem_wake_warp_i | input | WID_W | Warp the memory data returns to |
| bar_wake_valid_i | input | 1 | Barrier release wakeup |
| bar_wake_warp_i | input | WID_W | Warp released from the barrier |
| dep_wake_valid_i | input | 1 | Dependency resolved wakeup |
| dep_wake_warp_i | input | WID_W | Warp whose dependency resolved |
| done_valid_i | input | 1 | Warp finished its last instruction |
| done_warp_i | input | WID_W | Finished warp |
| issue_valid_o | output | 1 | A warp is granted this cycle |
| issue_warp_o | output | WID_W | Granted warp |
| issue_lane_mask_o | output | LANES | Lanes that receive the instruction |
| retire_valid_o | output | 1 | Retirement pulse |
| retire_warp_o | output | WID_W | Retired warp |
| retire_block_o | output | BLK_W | Parent block of the retired warp |

## Verification
A stall and a wakeup can reach the same warp in the same cycle. A grant and a stall request can also target the same warp in the same cycle. The bench provokes the first on purpose: it stalls a warp for a dependency, then drives a dependency wakeup and a barrier stall for that warp together. It then checks that only a later barrier wakeup returns the warp to the grant rotation. A long pseudo-random sweep over a four-warp pool overlaps every event class on every warp, including the second collision. An arithmetic model of slot states and the round-robin pointer predicts every grant and retirement pulse, and the bench compares them cycle by cycle.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_ELIG  = 2'd1,
    ST_STALL = 2'd2,
    ST_RET   = 2'd3
  } wis_state_e;

  typedef enum logic [1:0] {
    CS_NONE = 2'd0,
    CS_MEM  = 2'd1,
    CS_BAR  = 2'd2,
    CS_DEP  = 2'd3
  } wis_cause_e;
endpackage

// File: rtl/wis_slot.sv
module wis_slot
  import wis_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             admit_i,
  input  logic [BLK_W-1:0] admit_block_i,
  input  logic             done_i,
  input  logic             stall_i,
  input  wis_cause_e       stall_cause_i,
  input  logic             wake_mem_i,
  input  logic             wake_bar_i,
  input  logic             wake_dep_i,
  output wis_state_e       state_o,
  output logic [BLK_W-1:0] block_o,
  output logic             retire_o
);
  wis_state_e       st_q, st_d;
  wis_cause_e       cause_q, cause_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             active, free, wake_hit;

  assign active = (st_q == ST_ELIG) || (st_q == ST_STALL);
  assign free   = (st_q == ST_EMPTY) || (st_q == ST_RET);

  always_comb begin
    unique case (cause_q)
      CS_MEM:  wake_hit = wake_mem_i;
      CS_BAR:  wake_hit = wake_bar_i;
      CS_DEP:  wake_hit = wake_dep_i;
      default: wake_hit = 1'b0;
    endcase
  end

  // priority: admit (free slots) > done > stall > wake
  always_comb begin
    st_d     = st_q;
    cause_d  = cause_q;
    blk_d    = blk_q;
    retire_o = 1'b0;
    if (admit_i && free) begin
      st_d    = ST_ELIG;
      cause_d = CS_NONE;
      blk_d   = admit_block_i;
    end else if (done_i && active) begin
      st_d     = ST_RET;
      cause_d  = CS_NONE;
      retire_o = 1'b1;
    end else if (stall_i && active && stall_cause_i != CS_NONE) begin
      st_d    = ST_STALL;
      cause_d = stall_cause_i;
    end else if (st_q == ST_STALL && wake_hit) begin
      st_d    = ST_ELIG;
      cause_d = CS_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_EMPTY;
      cause_q <= CS_NONE;
      blk_q   <= '0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      blk_q   <= blk_d;
    end
  end

  assign state_o = st_q;
  assign block_o = blk_q;
endmodule

// File: rtl/wis_rr_arb.sv
module wis_rr_arb #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             grant_valid_o,
  output logic [IDX_W-1:0] grant_idx_o
);
  int idx;

  always_comb begin
    grant_valid_o = 1'b0;
    grant_idx_o   = '0;
    idx           = 0;
    for (int i = 1; i <= N; i++) begin
      idx = (int'(last_i) + i) % N;
      if (!grant_valid_o && req_i[idx]) begin
        grant_valid_o = 1'b1;
        grant_idx_o   = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int BLK_W     = 4,
  parameter int LANES     = 32,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             admit_valid_i,
  input  logic [WID_W-1:0] admit_warp_i,
  input  logic [BLK_W-1:0] admit_block_i,
  input  logic             stall_valid_i,
  input  logic [WID_W-1:0] stall_warp_i,
  input  logic [1:0]       stall_cause_i,
  input  logic             mem_wake_valid_i,
  input  logic [WID_W-1:0] mem_wake_warp_i,
  input  logic             bar_wake_valid_i,
  input  logic [WID_W-1:0] bar_wake_warp_i,
  input  logic             dep_wake_valid_i,
  input  logic [WID_W-1:0] dep_wake_warp_i,
  input  logic             done_valid_i,
  input  logic [WID_W-1:0] done_warp_i,
  output logic             issue_valid_o,
  output logic [WID_W-1:0] issue_warp_o,
  output logic [LANES-1:0] issue_lane_mask_o,
  output logic             retire_valid_o,
  output logic [WID_W-1:0] retire_warp_o,
  output logic [BLK_W-1:0] retire_block_o
);
  localparam logic [WID_W-1:0] LAST_INIT = WID_W'(NUM_WARPS - 1);

  logic [NUM_WARPS-1:0][1:0]       slot_state;
  logic [NUM_WARPS-1:0][BLK_W-1:0] slot_block;
  logic [NUM_WARPS-1:0]            slot_retire;
  logic [NUM_WARPS-1:0]            elig_mask;
  logic [WID_W-1:0]                last_q;
  logic                            grant_valid;
  logic [WID_W-1:0]                grant_idx;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    wis_state_e st;
    wis_slot #(.BLK_W(BLK_W)) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .admit_i       (admit_valid_i && admit_warp_i == WID_W'(w)),
      .admit_block_i (admit_block_i),
      .done_i        (done_valid_i && done_warp_i == WID_W'(w)),
      .stall_i       (stall_valid_i && stall_warp_i == WID_W'(w)),
      .stall_cause_i (wis_cause_e'(stall_cause_i)),
      .wake_mem_i    (mem_wake_valid_i && mem_wake_warp_i == WID_W'(w)),
      .wake_bar_i    (bar_wake_valid_i && bar_wake_warp_i == WID_W'(w)),
      .wake_dep_i    (dep_wake_valid_i && dep_wake_warp_i == WID_W'(w)),
      .state_o       (st),
      .block_o       (slot_block[w]),
      .retire_o      (slot_retire[w])
    );
    assign slot_state[w] = st;
    assign elig_mask[w]  = (st == ST_ELIG);
  end

  wis_rr_arb #(.N(NUM_WARPS), .IDX_W(WID_W)) u_arb (
    .req_i         (elig_mask),
    .last_i        (last_q),
    .grant_valid_o (grant_valid),
    .grant_idx_o   (grant_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= LAST_INIT;
    else if (grant_valid) last_q <= grant_idx;
  end

  assign issue_valid_o     = grant_valid;
  assign issue_warp_o      = grant_idx;
  assign issue_lane_mask_o = {LANES{grant_valid}};

  // single done channel: at most one slot retires per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retire_valid_o <= 1'b0;
      retire_warp_o  <= '0;
      retire_block_o <= '0;
    end else begin
      retire_valid_o <= |slot_retire;
      if (|slot_retire) begin
        retire_warp_o  <= done_warp_i;
        retire_block_o <= slot_block[done_warp_i];
      end
    end
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 8,
  parameter int WID_W     = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_WARPS-1:0][1:0] slot_state,
  input logic                      admit_valid_i,
  input logic [WID_W-1:0]          admit_warp_i,
  input logic                      stall_valid_i,
  input logic [WID_W-1:0]          stall_warp_i,
  input logic [1:0]                stall_cause_i,
  input logic                      done_valid_i,
  input logic [WID_W-1:0]          done_warp_i,
  input logic                      issue_valid_o,
  input logic [WID_W-1:0]          issue_warp_o,
  input logic                      retire_valid_o,
  input logic [WID_W-1:0]          retire_warp_o
);
  a_r3_issue_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> slot_state[issue_warp_o] == 2'd1);

  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_state[0] != 2'd1 && slot_state[NUM_WARPS-1] != 2'd1 &&
     $countones(issue_valid_o) == 1) |-> issue_warp_o != 0 && issue_warp_o != WID_W'(NUM_WARPS-1));

  a_r2_admit_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (admit_valid_i && (slot_state[admit_warp_i] == 2'd0 || slot_state[admit_warp_i] == 2'd3))
    |=> slot_state[$past(admit_warp_i)] == 2'd1);

  a_r5_stall_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_valid_i && stall_cause_i != 2'd0 &&
     (slot_state[stall_warp_i] == 2'd1 || slot_state[stall_warp_i] == 2'd2) &&
     !(done_valid_i && done_warp_i == stall_warp_i))
    |=> slot_state[$past(stall_warp_i)] == 2'd2);

  a_r9_retire_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> slot_state[retire_warp_o] == 2'd3);
endmodule

bind warp_issue_sched wis_checker #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_wis_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .slot_state     (slot_state),
  .admit_valid_i  (admit_valid_i),
  .admit_warp_i   (admit_warp_i),
  .stall_valid_i  (stall_valid_i),
  .stall_warp_i   (stall_warp_i),
  .stall_cause_i  (stall_cause_i),
  .done_valid_i   (done_valid_i),
  .done_warp_i    (done_warp_i),
  .issue_valid_o  (issue_valid_o),
  .issue_warp_o   (issue_warp_o),
  .retire_valid_o (retire_valid_o),
  .retire_warp_o  (retire_warp_o)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
  localparam int NW = 4;
  localparam int BW = 4;
  localparam int LN = 32;
  localparam int WW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          admit_valid_i = 0, stall_valid_i = 0, done_valid_i = 0;
  logic          mem_wake_valid_i = 0, bar_wake_valid_i = 0, dep_wake_valid_i = 0;
  logic [WW-1:0] admit_warp_i = 0, stall_warp_i = 0, done_warp_i = 0;
  logic [WW-1:0] mem_wake_warp_i = 0, bar_wake_warp_i = 0, dep_wake_warp_i = 0;
  logic [BW-1:0] admit_block_i = 0;
  logic [1:0]    stall_cause_i = 0;
  logic          issue_valid_o, retire_valid_o;
  logic [WW-1:0] issue_warp_o, retire_warp_o;
  logic [LN-1:0] issue_lane_mask_o;
  logic [BW-1:0] retire_block_o;

  always #4 clk_i = ~clk_i;

  warp_issue_sched #(.NUM_WARPS(NW), .BLK_W(BW), .LANES(LN)) dut_i (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  // bench model
  int m_st[NW], m_cause[NW], m_blk[NW];
  int m_last = NW - 1;
  bit m_rv = 0;
  int m_rw = 0, m_rb = 0;

  // staged stimulus
  bit s_av, s_sv, s_dv, s_mv, s_bv, s_pv;
  int s_aw, s_ab, s_sw, s_sc, s_dw, s_mw, s_bw, s_pw;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pick();
    for (int i = 1; i <= NW; i++) begin
      int k = (m_last + i) % NW;
      if (m_st[k] == 1) return k;
    end
    return -1;
  endfunction

  task automatic clr_stim();
    s_av = 0; s_sv = 0; s_dv = 0; s_mv = 0; s_bv = 0; s_pv = 0;
    s_aw = 0; s_ab = 0; s_sw = 0; s_sc = 0; s_dw = 0; s_mw = 0; s_bw = 0; s_pw = 0;
  endtask

  task automatic cyc();
    int p;
    int n_st[NW], n_cause[NW], n_blk[NW];
    bit n_rv;
    int n_rw, n_rb;
    @(negedge clk_i);
    admit_valid_i = s_av; admit_warp_i = WW'(s_aw); admit_block_i = BW'(s_ab);
    stall_valid_i = s_sv; stall_warp_i = WW'(s_sw); stall_cause_i = 2'(s_sc);
    done_valid_i = s_dv; done_warp_i = WW'(s_dw);
    mem_wake_valid_i = s_mv; mem_wake_warp_i = WW'(s_mw);
    bar_wake_valid_i = s_bv; bar_wake_warp_i = WW'(s_bw);
    dep_wake_valid_i = s_pv; dep_wake_warp_i = WW'(s_pw);
    #1;
    p = pick();
    chk(cur_req, "issue_valid", int'(issue_valid_o), int'(p >= 0));
    chk(cur_req, "issue_warp", int'(issue_warp_o), (p >= 0) ? p : 0);
    chk("R3", "lane_mask_ones", int'(issue_lane_mask_o == '1), int'(p >= 0));
    chk("R9", "retire_valid", int'(retire_valid_o), int'(m_rv));
    if (m_rv) begin
      chk("R9", "retire_warp", int'(retire_warp_o), m_rw);
      chk("R9", "retire_block", int'(retire_block_o), m_rb);
    end
    n_rv = 0; n_rw = 0; n_rb = 0;
    for (int w = 0; w < NW; w++) begin
      bit act = (m_st[w] == 1 || m_st[w] == 2);
      bit wk = (m_cause[w] == 1 && s_mv && s_mw == w) ||
               (m_cause[w] == 2 && s_bv && s_bw == w) ||
               (m_cause[w] == 3 && s_pv && s_pw == w);
      n_st[w] = m_st[w]; n_cause[w] = m_cause[w]; n_blk[w] = m_blk[w];
      if (s_av && s_aw == w && !act) begin
        n_st[w] = 1; n_cause[w] = 0; n_blk[w] = s_ab;
      end else if (s_dv && s_dw == w && act) begin
        n_st[w] = 3; n_cause[w] = 0; n_rv = 1; n_rw = w; n_rb = m_blk[w];
      end else if (s_sv && s_sw == w && act && s_sc != 0) begin
        n_st[w] = 2; n_cause[w] = s_sc;
      end else if (m_st[w] == 2 && wk) begin
        n_st[w] = 1; n_cause[w] = 0;
      end
    end
    clr_stim();
    @(posedge clk_i);
    if (p >= 0) m_last = p;
    m_st = n_st; m_cause = n_cause; m_blk = n_blk;
    m_rv = n_rv; m_rw = n_rw; m_rb = n_rb;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned rs;
    for (int w = 0; w < NW; w++) begin m_st[w] = 0; m_cause[w] = 0; m_blk[w] = 0; end
    clr_stim();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "issue_valid_in_reset", int'(issue_valid_o), 0);
    chk("R1", "retire_valid_in_reset", int'(retire_valid_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cur_req = "R8"; idle(3);

    cur_req = "R2";
    for (int w = 0; w < NW; w++) begin s_av = 1; s_aw = w; s_ab = 5 + w; cyc(); end
    s_av = 1; s_aw = 0; s_ab = 15; cyc();
    cur_req = "R4"; idle(6);

    cur_req = "R5"; s_sv = 1; s_sw = 1; s_sc = 1; cyc(); idle(5);
    s_sv = 1; s_sw = 0; s_sc = 0; cyc(); idle(3);
    cur_req = "R6"; s_bv = 1; s_bw = 1; s_pv = 1; s_pw = 1; cyc(); idle(4);
    s_mv = 1; s_mw = 1; cyc(); idle(4);

    cur_req = "R7"; s_sv = 1; s_sw = 2; s_sc = 3; cyc(); idle(2);
    s_pv = 1; s_pw = 2; s_sv = 1; s_sw = 2; s_sc = 2; cyc(); idle(4);
    s_pv = 1; s_pw = 2; cyc(); idle(3);
    s_bv = 1; s_bw = 2; cyc(); idle(4);

    cur_req = "R9"; s_dv = 1; s_dw = 3; cyc(); idle(6);
    s_dv = 1; s_dw = 3; cyc(); idle(2);
    s_dv = 1; s_dw = 0; s_sv = 1; s_sw = 0; s_sc = 1; cyc(); idle(3);
    cur_req = "R2"; s_av = 1; s_aw = 3; s_ab = 9; cyc(); idle(4);
    cur_req = "R8";
    for (int w = 0; w < NW; w++) begin s_dv = 1; s_dw = w; cyc(); end
    idle(3);

    cur_req = "R3";
    rs = 32'h1234_5679;
    for (int i = 0; i < 6000; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      s_av = rs[0] & rs[1]; s_aw = int'(rs[3:2]); s_ab = int'(rs[7:4]);
      s_sv = rs[8]; s_sw = int'(rs[10:9]); s_sc = int'(rs[12:11]);
      s_mv = rs[13]; s_mw = int'(rs[15:14]);
      s_bv = rs[16]; s_bw = int'(rs[18:17]);
      s_pv = rs[19]; s_pw = int'(rs[21:20]);
      s_dv = (rs[25:22] == 4'd0); s_dw = int'(rs[27:26]);
      cyc();
    end
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule